// File: doc/BRIEF.md
# Lowest Set Bit Index Finder

A purely combinational unit that takes a 64-bit word and returns the bit position of its least significant 1. For any nonzero word this position equals the number of trailing zeros. A separate flag reports an all-zero word. The unit is intended as the core of a priority encoder, where the lowest numbered active request wins.

Internally the word is combined with its two's-complement negation in two ways. The AND of the two isolates the lowest 1 as a one-hot vector. The two low index bits come from wide ORs over that vector. The OR of the two gives a thermometer mask, with ones from the top bit down to the lowest 1 and zeros below it. Each of the four upper index bits comes from a handful of sampled mask bits: a result bit k looks only at mask positions of the form j*2^k - 1. The zero flag is the inverse of the top mask bit.

Top module: `lsb_index_find`

## Requirements
- R1: For any nonzero input, `idx_o` equals the position of the least significant 1 bit of `word_i`, where bit 0 is the rightmost bit.
- R2: When `word_i` is all zeros, `zero_o` is 1 and `idx_o` is 0.
- R3: For a word with a single 1 at position p, `idx_o` equals p for every p from 0 to 63.
- R4: Bits above the least significant 1 have no effect on `idx_o`. Words that share their lowest 1 at position p give the same index p, whatever their upper bits are.
- R5: An all-ones word gives index 0, and a word with only bit 63 set gives index 63.
- R6: `zero_o` is 0 for every nonzero input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 64 | Word to be scanned |
| idx_o | output | 6 | Position of the least significant 1 bit |
| zero_o | output | 1 | High when the word has no 1 bits |

## Verification
The immediate assertions assume that `word_i` settles to known 0/1 values and is stable while the outputs are read. They also assume that no check of the index applies while the zero flag is set, because the index is defined only for nonzero words. The bench changes the input only away from the sampling edge. It applies only fully defined 64-bit values: every single-bit word, words with the lowest 1 at each position and random bits above it, dense and sparse random words, and the two extremes. The bench checks the index against a bit-by-bit loop only when the word is nonzero.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
    localparam int unsigned WORD_W_DEF   = 64;
    localparam int unsigned LOW_BITS_DEF = 2;

    function automatic bit is_pow2(input int unsigned n);
        return (n != 0) && ((n & (n - 1)) == 0);
    endfunction
endpackage

// File: rtl/lsb_helpers.sv
module lsb_helpers #(
    parameter int unsigned W = lsb_pkg::WORD_W_DEF
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] iso_o,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] neg;

    always_comb begin
        neg    = ~word_i + W'(1);
        iso_o  = word_i & neg;
        mask_o = word_i | neg;
    end

    // R1: the isolated vector carries exactly one 1 for a nonzero word
    always_comb begin
        if (word_i != '0)
            a_r1_iso_onehot: assert ($onehot(iso_o));
    end
endmodule

// File: rtl/lsb_low_enc.sv
module lsb_low_enc #(
    parameter int unsigned W    = lsb_pkg::WORD_W_DEF,
    parameter int unsigned LOWB = lsb_pkg::LOW_BITS_DEF
) (
    input  logic [W-1:0]    iso_i,
    output logic [LOWB-1:0] idx_lo_o
);
    for (genvar k = 0; k < LOWB; k++) begin : g_bit
        logic [W-1:0] sel;
        for (genvar j = 0; j < W; j++) begin : g_pos
            if (((j >> k) & 1) == 1) begin : g_on
                assign sel[j] = iso_i[j];
            end else begin : g_off
                assign sel[j] = 1'b0;
            end
        end
        assign idx_lo_o[k] = |sel;
    end
endmodule

// File: rtl/lsb_high_enc.sv
module lsb_high_enc #(
    parameter int unsigned W    = lsb_pkg::WORD_W_DEF,
    parameter int unsigned LOWB = lsb_pkg::LOW_BITS_DEF,
    localparam int unsigned IW  = $clog2(W),
    localparam int unsigned HIW = IW - LOWB
) (
    input  logic [W-1:0]   mask_i,
    output logic [HIW-1:0] idx_hi_o
);
    for (genvar h = 0; h < HIW; h++) begin : g_bit
        localparam int unsigned K   = h + LOWB;
        localparam int unsigned SEG = 1 << K;
        localparam int unsigned NT  = W >> (K + 1);
        logic [NT-1:0] term;
        // lowest 1 lies in an odd segment m: mask clear at m*SEG-1, set at (m+1)*SEG-1
        for (genvar t = 0; t < NT; t++) begin : g_term
            assign term[t] = ~mask_i[(2*t+1)*SEG-1] & mask_i[(2*t+2)*SEG-1];
        end
        assign idx_hi_o[h] = |term;
    end
endmodule

// File: rtl/lsb_index_find.sv
module lsb_index_find #(
    parameter int unsigned W    = lsb_pkg::WORD_W_DEF,
    parameter int unsigned LOWB = lsb_pkg::LOW_BITS_DEF,
    localparam int unsigned IW  = $clog2(W)
) (
    input  logic [W-1:0]  word_i,
    output logic [IW-1:0] idx_o,
    output logic          zero_o
);
    logic [W-1:0]       iso, mask;
    logic [LOWB-1:0]    idx_lo;
    logic [IW-LOWB-1:0] idx_hi;

    initial begin
        if (!lsb_pkg::is_pow2(W) || LOWB >= IW)
            $error("lsb_index_find: W must be a power of two and LOWB below log2(W)");
    end

    lsb_helpers  #(.W(W))              u_help (.word_i(word_i), .iso_o(iso), .mask_o(mask));
    lsb_low_enc  #(.W(W), .LOWB(LOWB)) u_lo   (.iso_i(iso), .idx_lo_o(idx_lo));
    lsb_high_enc #(.W(W), .LOWB(LOWB)) u_hi   (.mask_i(mask), .idx_hi_o(idx_hi));

    assign idx_o  = {idx_hi, idx_lo};
    assign zero_o = ~mask[W-1];

    always_comb begin
        a_r2_zero_flag: assert (zero_o == (word_i == '0));
        if (zero_o)
            a_r2_zero_idx: assert (idx_o == '0);
        else begin
            a_r1_bit_set: assert (word_i[idx_o] == 1'b1);
            a_r4_below_clear: assert ((word_i & ((W'(1) << idx_o) - W'(1))) == '0);
        end
    end
endmodule

// File: tb/lsb_index_find_tb_top.sv
module lsb_index_find_tb_top;
    localparam int unsigned W  = 64;
    localparam int unsigned IW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  word;
    logic [IW-1:0] idx;
    logic          zero;
    int            errors = 0;
    int            checks = 0;
    bit            done   = 1'b0;

    always #2.5 clk = ~clk;

    lsb_index_find dut_i (.word_i(word), .idx_o(idx), .zero_o(zero));

    function automatic int ref_idx(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic apply_check(input logic [W-1:0] v, input int exp_i, input string req);
        @(posedge clk);
        #1 word = v;
        @(negedge clk);
        checks++;
        if (v == '0) begin
            if (zero !== 1'b1) begin
                errors++;
                $display("FAIL %s zero flag: word=%h actual=%b expected=1", req, v, zero);
            end
        end else if (zero !== 1'b0 || idx !== IW'(exp_i)) begin
            errors++;
            $display("FAIL %s word=%h actual idx=%0d zero=%b expected idx=%0d zero=0",
                     req, v, idx, zero, exp_i);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst  = 1'b1;
        word = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R2: zero word after reset, index must also read 0
        @(negedge clk);
        checks++;
        if (zero !== 1'b1 || idx !== '0) begin
            errors++;
            $display("FAIL R2 reset: actual zero=%b idx=%0d expected zero=1 idx=0", zero, idx);
        end
        // R3: every single-bit word
        for (int p = 0; p < W; p++) apply_check(W'(1) << p, p, "R3");
        // R4: lowest one at p with random upper bits
        for (int p = 0; p < W; p++) begin
            for (int r = 0; r < 4; r++) begin
                logic [W-1:0] v;
                v = {$urandom, $urandom};
                v = (v & ~((W'(1) << p) - W'(1))) | (W'(1) << p);
                apply_check(v, p, "R4");
            end
        end
        // R5: extremes
        apply_check('1, 0, "R5");
        apply_check(W'(1) << (W - 1), W - 1, "R5");
        // R1 and R6: dense and sparse random words
        for (int n = 0; n < 2000; n++) begin
            logic [W-1:0] v;
            v = {$urandom, $urandom};
            if (n % 2 == 1) v = v & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if (n % 7 == 3) v = v & ~((W'(1) << (n % W)) - W'(1));
            apply_check(v, ref_idx(v), v == '0 ? "R2" : "R1/R6");
        end
        // R2: back to zero after nonzero traffic
        apply_check('0, 0, "R2");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule